// File: doc/BRIEF.md
# Pipeline hazard and forwarding controller

This block is the interlock and bypass control for a five-stage integer pipeline (fetch, decode, execute, memory, writeback) with 32 general registers. Each cycle it compares the source registers of the instruction in decode with the destinations held in the decode/execute and execute/memory pipeline registers. From that comparison it decides whether the fetch address and the fetch/decode register must hold while a bubble enters decode/execute. It also picks, one cycle ahead, where each execute operand comes from. The datapath, ALU, register file and memories sit outside; they obey the hold, bubble and select outputs.

A static input chooses the policy. With bypassing off, a dependent instruction waits in decode until its producer is in writeback; the register file writes before it reads in that cycle. With bypassing on, only a load whose result is needed by the very next instruction costs a wait cycle. Whenever a branch leaves decode, the controller adds exactly one bubble behind it. Three event counters (data-wait cycles, branch bubbles, retired instructions) let software-free measurement of CPI: total cycles of a trace equal retired plus waits plus bubbles plus four drain cycles.

Control is a two-state machine. In state FLOW the controller passes instructions on, or holds on a data hazard (transition FLOW to FLOW). The transition FLOW to BR_SHADOW is taken when a branch leaves decode with no hazard. In state BR_SHADOW the controller holds the front end and inserts a bubble for one cycle, then always takes BR_SHADOW to FLOW. The branch flag is ignored while in BR_SHADOW.

Top module: `hazard_fwd_ctrl`

## Requirements
- R1: During and just after synchronous reset (rst high), pc_hold, ifid_hold and idex_bubble are 0, both operand selects are 0, and all three counters read 0.
- R2: With byp_en low, a used, nonzero source that equals the destination of a writing entry in decode/execute or in execute/memory raises pc_hold, ifid_hold and idex_bubble in that same cycle; the operand selects are then always 0.
- R3: With byp_en high, a hold occurs only when decode/execute carries a writing load (dx_load=1) whose destination equals a used, nonzero source; a non-load producer in decode/execute never causes a hold.
- R4: Register index 0 and sources whose use flag is low never cause a hold and never produce a nonzero operand select.
- R5: Operand select codes are 0 = register file, 1 = execute/memory result, 2 = memory/writeback result. They are registered and valid in the cycle after the instruction leaves decode. A match in decode/execute gives 1, a match only in execute/memory gives 2, and a match in both gives 1.
- R6: A branch that leaves decode with no hazard (id_branch=1, no hold) causes exactly one following cycle with all hold and bubble outputs high, after which holds drop. id_branch is ignored during that cycle; a branch that must wait gets its bubble after the wait ends.
- R7: In any cycle with a hold, both operand selects registered at the next edge are 0 (the bubble needs no bypass).
- R8: stall_count rises by one for each data-hazard hold cycle, bubble_count by one for each branch bubble cycle, and retire_count by one for each cycle with mw_valid high. All three are 32 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byp_en | input | 1 | 1 = full bypassing, 0 = interlock until writeback |
| id_rs1 | input | 5 | First source index of decode instruction |
| id_rs1_use | input | 1 | First source is read |
| id_rs2 | input | 5 | Second source index of decode instruction |
| id_rs2_use | input | 1 | Second source is read |
| id_branch | input | 1 | Decode instruction is a branch |
| dx_rd | input | 5 | Destination in decode/execute register |
| dx_we | input | 1 | Decode/execute entry writes a register |
| dx_load | input | 1 | Decode/execute entry is a load |
| xm_rd | input | 5 | Destination in execute/memory register |
| xm_we | input | 1 | Execute/memory entry writes a register |
| mw_valid | input | 1 | Non-bubble entry leaving writeback |
| pc_hold | output | 1 | Keep fetch address |
| ifid_hold | output | 1 | Keep fetch/decode register |
| idex_bubble | output | 1 | Load a bubble into decode/execute |
| fwd_a_sel | output | 2 | First execute operand source |
| fwd_b_sel | output | 2 | Second execute operand source |
| stall_count | output | 32 | Data-hazard hold cycles |
| bubble_count | output | 32 | Branch bubble cycles |
| retire_count | output | 32 | Retired instructions |

## Verification
The assertions assume that byp_en only changes when no instruction depends on the previous setting. They also assume that use flags are low when decode holds no instruction, and that the stage inputs describe a bubble with its write enable cleared. The stimulus keeps to this: each table vector presents a complete, self-consistent snapshot of the stage registers for one cycle, then lets the edge pass. The directed sequences change the producer fields only as the real pipeline would after a hold has let the producer advance.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
    localparam int REG_IDX_W = 5;
    localparam int EVT_CNT_W = 32;

    typedef enum logic [1:0] {
        SRC_REGFILE = 2'd0,
        SRC_EXMEM   = 2'd1,
        SRC_MEMWB   = 2'd2
    } fwd_src_e;

    typedef enum logic {
        ST_FLOW      = 1'b0,
        ST_BR_SHADOW = 1'b1
    } ctl_state_e;
endpackage

// File: rtl/hzc_src_conflict.sv
module hzc_src_conflict #(
    parameter int IDX_W = 5,
    parameter int NSRC  = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       byp_en,
    input  logic [NSRC-1:0][IDX_W-1:0] src_idx,
    input  logic [NSRC-1:0]            src_use,
    input  logic [IDX_W-1:0]           dx_rd,
    input  logic                       dx_we,
    input  logic                       dx_load,
    input  logic [IDX_W-1:0]           xm_rd,
    input  logic                       xm_we,
    output logic                       raw_stall
);
    logic [NSRC-1:0] conflict;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic live;
        logic hit_dx;
        logic hit_xm;

        always_comb begin
            live   = src_use[i] && (src_idx[i] != '0);
            hit_dx = dx_we && (dx_rd == src_idx[i]);
            hit_xm = xm_we && (xm_rd == src_idx[i]);
            if (byp_en)
                conflict[i] = live && hit_dx && dx_load;
            else
                conflict[i] = live && (hit_dx || hit_xm);
        end

        // R4
        zero_src_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            ((src_idx[i] == '0) || !src_use[i]) |-> !conflict[i]);
    end

    assign raw_stall = |conflict;

    // R3
    alu_no_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (byp_en && !dx_load) |-> !raw_stall);
endmodule

// File: rtl/hzc_fwd_pick.sv
module hzc_fwd_pick
    import hzc_pkg::*;
#(
    parameter int IDX_W = 5,
    parameter int NSRC  = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       byp_en,
    input  logic                       advance,
    input  logic [NSRC-1:0][IDX_W-1:0] src_idx,
    input  logic [NSRC-1:0]            src_use,
    input  logic [IDX_W-1:0]           dx_rd,
    input  logic                       dx_we,
    input  logic [IDX_W-1:0]           xm_rd,
    input  logic                       xm_we,
    output logic [NSRC-1:0][1:0]       sel_q
);
    for (genvar i = 0; i < NSRC; i++) begin : g_op
        logic [1:0] sel_d;

        always_comb begin
            sel_d = SRC_REGFILE;
            if (byp_en && src_use[i] && (src_idx[i] != '0)) begin
                if (dx_we && (dx_rd == src_idx[i]))
                    sel_d = SRC_EXMEM;
                else if (xm_we && (xm_rd == src_idx[i]))
                    sel_d = SRC_MEMWB;
            end
        end

        always_ff @(posedge clk) begin
            if (rst)
                sel_q[i] <= SRC_REGFILE;
            else if (advance)
                sel_q[i] <= sel_d;
            else
                sel_q[i] <= SRC_REGFILE;
        end

        // R2
        interlock_regfile_chk: assert property (@(posedge clk) disable iff (rst)
            !byp_en |=> (sel_q[i] == SRC_REGFILE));
        // R4
        zero_src_nofwd_chk: assert property (@(posedge clk) disable iff (rst)
            (src_idx[i] == '0) |=> (sel_q[i] == SRC_REGFILE));
        // R7
        hold_clears_sel_chk: assert property (@(posedge clk) disable iff (rst)
            !advance |=> (sel_q[i] == SRC_REGFILE));
        // R5
        sel_code_legal_chk: assert property (@(posedge clk) disable iff (rst)
            sel_q[i] != 2'd3);
    end
endmodule

// File: rtl/hzc_event_counters.sv
module hzc_event_counters #(
    parameter int CNT_W = 32,
    parameter int NEV   = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NEV-1:0]            ev,
    output logic [NEV-1:0][CNT_W-1:0] cnt
);
    for (genvar e = 0; e < NEV; e++) begin : g_ev
        always_ff @(posedge clk) begin
            if (rst)
                cnt[e] <= '0;
            else if (ev[e])
                cnt[e] <= cnt[e] + 1'b1;
        end

        // R8
        count_step_chk: assert property (@(posedge clk) disable iff (rst)
            ev[e] |=> (cnt[e] == $past(cnt[e]) + 1'b1));
        // R8
        count_still_chk: assert property (@(posedge clk) disable iff (rst)
            !ev[e] |=> $stable(cnt[e]));
    end
endmodule

// File: rtl/hazard_fwd_ctrl.sv
module hazard_fwd_ctrl
    import hzc_pkg::*;
#(
    parameter int IDX_W = REG_IDX_W,
    parameter int CNT_W = EVT_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             byp_en,
    input  logic [IDX_W-1:0] id_rs1,
    input  logic             id_rs1_use,
    input  logic [IDX_W-1:0] id_rs2,
    input  logic             id_rs2_use,
    input  logic             id_branch,
    input  logic [IDX_W-1:0] dx_rd,
    input  logic             dx_we,
    input  logic             dx_load,
    input  logic [IDX_W-1:0] xm_rd,
    input  logic             xm_we,
    input  logic             mw_valid,
    output logic             pc_hold,
    output logic             ifid_hold,
    output logic             idex_bubble,
    output logic [1:0]       fwd_a_sel,
    output logic [1:0]       fwd_b_sel,
    output logic [CNT_W-1:0] stall_count,
    output logic [CNT_W-1:0] bubble_count,
    output logic [CNT_W-1:0] retire_count
);
    localparam int NSRC = 2;
    localparam int NEV  = 3;
    localparam int EV_STALL  = 0;
    localparam int EV_BUBBLE = 1;
    localparam int EV_RETIRE = 2;

    logic [NSRC-1:0][IDX_W-1:0] src_idx;
    logic [NSRC-1:0]            src_use;
    logic [NSRC-1:0][1:0]       sel_q;
    logic [NEV-1:0]             ev;
    logic [NEV-1:0][CNT_W-1:0]  cnt;

    ctl_state_e state_q, state_d;
    logic data_stall;
    logic hold;
    logic stall_ev;
    logic bubble_ev;

    assign src_idx = {id_rs2, id_rs1};
    assign src_use = {id_rs2_use, id_rs1_use};

    hzc_src_conflict #(.IDX_W(IDX_W), .NSRC(NSRC)) u_conf (
        .clk       (clk),
        .rst       (rst),
        .byp_en    (byp_en),
        .src_idx   (src_idx),
        .src_use   (src_use),
        .dx_rd     (dx_rd),
        .dx_we     (dx_we),
        .dx_load   (dx_load),
        .xm_rd     (xm_rd),
        .xm_we     (xm_we),
        .raw_stall (data_stall)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_FLOW;
        else
            state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        hold      = 1'b0;
        stall_ev  = 1'b0;
        bubble_ev = 1'b0;
        unique case (state_q)
            ST_FLOW: begin
                hold     = data_stall;
                stall_ev = data_stall;
                if (!data_stall && id_branch)
                    state_d = ST_BR_SHADOW;
            end
            ST_BR_SHADOW: begin
                hold      = 1'b1;
                bubble_ev = 1'b1;
                state_d   = ST_FLOW;
            end
            default: state_d = ST_FLOW;
        endcase
    end

    assign pc_hold     = hold;
    assign ifid_hold   = hold;
    assign idex_bubble = hold;

    hzc_fwd_pick #(.IDX_W(IDX_W), .NSRC(NSRC)) u_pick (
        .clk     (clk),
        .rst     (rst),
        .byp_en  (byp_en),
        .advance (!hold),
        .src_idx (src_idx),
        .src_use (src_use),
        .dx_rd   (dx_rd),
        .dx_we   (dx_we),
        .xm_rd   (xm_rd),
        .xm_we   (xm_we),
        .sel_q   (sel_q)
    );

    assign fwd_a_sel = sel_q[0];
    assign fwd_b_sel = sel_q[1];

    always_comb begin
        ev            = '0;
        ev[EV_STALL]  = stall_ev;
        ev[EV_BUBBLE] = bubble_ev;
        ev[EV_RETIRE] = mw_valid;
    end

    hzc_event_counters #(.CNT_W(CNT_W), .NEV(NEV)) u_cnt (
        .clk (clk),
        .rst (rst),
        .ev  (ev),
        .cnt (cnt)
    );

    assign stall_count  = cnt[EV_STALL];
    assign bubble_count = cnt[EV_BUBBLE];
    assign retire_count = cnt[EV_RETIRE];

    // R6
    shadow_single_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BR_SHADOW) |=> (state_q == ST_FLOW));
    // R6
    branch_bubble_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FLOW && id_branch && !data_stall) |=> idex_bubble);
    // R6
    no_stall_count_in_shadow_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BR_SHADOW) |=> $stable(stall_count));
endmodule

// File: tb/sim_hazard_fwd_ctrl.sv
module sim_hazard_fwd_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        byp_en = 1'b0;
    logic [4:0]  id_rs1 = '0;
    logic        id_rs1_use = 1'b0;
    logic [4:0]  id_rs2 = '0;
    logic        id_rs2_use = 1'b0;
    logic        id_branch = 1'b0;
    logic [4:0]  dx_rd = '0;
    logic        dx_we = 1'b0;
    logic        dx_load = 1'b0;
    logic [4:0]  xm_rd = '0;
    logic        xm_we = 1'b0;
    logic        mw_valid = 1'b0;
    logic        pc_hold, ifid_hold, idex_bubble;
    logic [1:0]  fwd_a_sel, fwd_b_sel;
    logic [31:0] stall_count, bubble_count, retire_count;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    hazard_fwd_ctrl u0 (
        .clk(clk), .rst(rst), .byp_en(byp_en),
        .id_rs1(id_rs1), .id_rs1_use(id_rs1_use),
        .id_rs2(id_rs2), .id_rs2_use(id_rs2_use),
        .id_branch(id_branch),
        .dx_rd(dx_rd), .dx_we(dx_we), .dx_load(dx_load),
        .xm_rd(xm_rd), .xm_we(xm_we), .mw_valid(mw_valid),
        .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
        .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
        .stall_count(stall_count), .bubble_count(bubble_count),
        .retire_count(retire_count)
    );

    typedef struct packed {
        logic       fe;
        logic [4:0] r1;
        logic       u1;
        logic [4:0] r2;
        logic       u2;
        logic [4:0] xd;
        logic       xw;
        logic       xl;
        logic [4:0] md;
        logic       mw;
        logic       stl;
        logic [1:0] sa;
        logic [1:0] sb;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        // R2 match in decode/execute
        '{1'b0, 5'd3, 1'b1, 5'd4, 1'b1, 5'd3, 1'b1, 1'b0, 5'd0, 1'b0, 1'b1, 2'd0, 2'd0, 4'd2},
        // R2 match in execute/memory
        '{1'b0, 5'd3, 1'b1, 5'd4, 1'b1, 5'd9, 1'b1, 1'b0, 5'd4, 1'b1, 1'b1, 2'd0, 2'd0, 4'd2},
        // R2 no match
        '{1'b0, 5'd3, 1'b1, 5'd4, 1'b1, 5'd9, 1'b1, 1'b0, 5'd8, 1'b1, 1'b0, 2'd0, 2'd0, 4'd2},
        // R4 unused source
        '{1'b0, 5'd3, 1'b1, 5'd4, 1'b0, 5'd9, 1'b1, 1'b0, 5'd4, 1'b1, 1'b0, 2'd0, 2'd0, 4'd4},
        // R4 register zero, interlock mode
        '{1'b0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0, 1'b1, 1'b0, 5'd0, 1'b1, 1'b0, 2'd0, 2'd0, 4'd4},
        // R2 producers not writing
        '{1'b0, 5'd3, 1'b1, 5'd4, 1'b1, 5'd3, 1'b0, 1'b0, 5'd4, 1'b0, 1'b0, 2'd0, 2'd0, 4'd2},
        // R3 ALU producers bypassed, R5 codes
        '{1'b1, 5'd3, 1'b1, 5'd4, 1'b1, 5'd3, 1'b1, 1'b0, 5'd4, 1'b1, 1'b0, 2'd1, 2'd2, 4'd3},
        // R3 load-use wait
        '{1'b1, 5'd3, 1'b1, 5'd4, 1'b1, 5'd3, 1'b1, 1'b1, 5'd0, 1'b0, 1'b1, 2'd0, 2'd0, 4'd3},
        // R3 load result not used next
        '{1'b1, 5'd5, 1'b1, 5'd4, 1'b1, 5'd3, 1'b1, 1'b1, 5'd5, 1'b1, 1'b0, 2'd2, 2'd0, 4'd3},
        // R5 both stages match: younger wins
        '{1'b1, 5'd6, 1'b1, 5'd6, 1'b1, 5'd6, 1'b1, 1'b0, 5'd6, 1'b1, 1'b0, 2'd1, 2'd1, 4'd5},
        // R4 register zero, bypass mode with load
        '{1'b1, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1, 1'b0, 2'd0, 2'd0, 4'd4},
        // R4 unused first source in bypass mode
        '{1'b1, 5'd7, 1'b0, 5'd7, 1'b1, 5'd7, 1'b1, 1'b0, 5'd7, 1'b1, 1'b0, 2'd0, 2'd1, 4'd4},
        // R5 older producer only
        '{1'b1, 5'd2, 1'b1, 5'd8, 1'b1, 5'd9, 1'b1, 1'b0, 5'd2, 1'b1, 1'b0, 2'd2, 2'd0, 4'd5}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic idle();
        byp_en = 1'b0; id_rs1 = '0; id_rs1_use = 1'b0; id_rs2 = '0; id_rs2_use = 1'b0;
        id_branch = 1'b0; dx_rd = '0; dx_we = 1'b0; dx_load = 1'b0;
        xm_rd = '0; xm_we = 1'b0; mw_valid = 1'b0;
    endtask

    task automatic next_slot();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected below 5000", cyc);
            finish_run();
        end
    end

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 hold", {29'd0, pc_hold, ifid_hold, idex_bubble}, 32'd0);
        chk("R1 selects", {28'd0, fwd_a_sel, fwd_b_sel}, 32'd0);
        chk("R1 stall_count", stall_count, 32'd0);
        chk("R1 bubble_count", bubble_count, 32'd0);
        chk("R1 retire_count", retire_count, 32'd0);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            byp_en = TBL[k].fe;
            id_rs1 = TBL[k].r1; id_rs1_use = TBL[k].u1;
            id_rs2 = TBL[k].r2; id_rs2_use = TBL[k].u2;
            dx_rd = TBL[k].xd; dx_we = TBL[k].xw; dx_load = TBL[k].xl;
            xm_rd = TBL[k].md; xm_we = TBL[k].mw;
            #1;
            chk($sformatf("R%0d vec%0d hold", TBL[k].req, k),
                {29'd0, pc_hold, ifid_hold, idex_bubble},
                {29'd0, TBL[k].stl, TBL[k].stl, TBL[k].stl});
            next_slot();
            chk($sformatf("R%0d vec%0d sel_a", TBL[k].req, k), {30'd0, fwd_a_sel}, {30'd0, TBL[k].sa});
            chk($sformatf("R%0d vec%0d sel_b", TBL[k].req, k), {30'd0, fwd_b_sel}, {30'd0, TBL[k].sb});
        end
        idle();
        #1;
        // R8 three table vectors held
        chk("R8 stall_count after table", stall_count, 32'd3);
        chk("R8 bubble_count after table", bubble_count, 32'd0);

        // R6 branch leaves decode, one bubble follows
        byp_en = 1'b1; id_branch = 1'b1;
        #1;
        chk("R6 branch passes", {31'd0, pc_hold}, 32'd0);
        next_slot();
        // shadow cycle: branch flag and a bypassable hazard present
        id_rs1 = 5'd3; id_rs1_use = 1'b1; dx_rd = 5'd3; dx_we = 1'b1;
        #1;
        chk("R6 shadow hold", {29'd0, pc_hold, ifid_hold, idex_bubble}, 32'd7);
        next_slot();
        chk("R7 select cleared after hold", {30'd0, fwd_a_sel}, 32'd0);
        chk("R8 shadow not a stall", stall_count, 32'd3);
        chk("R8 one bubble", bubble_count, 32'd1);
        idle();
        #1;
        chk("R6 single bubble only", {31'd0, pc_hold}, 32'd0);
        next_slot();

        // R6 branch that must wait first
        byp_en = 1'b0; id_branch = 1'b1; id_rs1 = 5'd3; id_rs1_use = 1'b1;
        dx_rd = 5'd3; dx_we = 1'b1;
        #1;
        chk("R2 branch waits on data", {31'd0, idex_bubble}, 32'd1);
        next_slot();
        dx_we = 1'b0;
        #1;
        chk("R6 branch passes after wait", {31'd0, idex_bubble}, 32'd0);
        next_slot();
        idle();
        #1;
        chk("R6 bubble after wait", {31'd0, idex_bubble}, 32'd1);
        next_slot();
        chk("R8 stall_count", stall_count, 32'd4);
        chk("R8 bubble_count", bubble_count, 32'd2);

        // R8 retirement
        mw_valid = 1'b1;
        repeat (5) @(posedge clk);
        #1;
        mw_valid = 1'b0;
        chk("R8 retire_count", retire_count, 32'd5);
        next_slot();
        chk("R8 retire_count stable", retire_count, 32'd5);

        // R1 reset mid-run
        rst = 1'b1;
        next_slot();
        chk("R1 stall_count cleared", stall_count, 32'd0);
        chk("R1 bubble_count cleared", bubble_count, 32'd0);
        chk("R1 retire_count cleared", retire_count, 32'd0);
        rst = 1'b0;
        next_slot();

        finish_run();
    end
endmodule